// File: doc/BRIEF.md
# Presettable Binary Up/Down Counter

This block is a small synchronous binary counter whose direction is picked each cycle by a direction input. Counting happens on the rising clock edge. It only happens when the active-low enable is low and the preset input is idle.

Two level-sensitive controls act without waiting for a clock. A preset input makes the count follow the data bus for as long as it is held. A clear input forces the count to zero and wins over everything else, including the preset.

An active-low terminal-count flag is decoded combinationally from the count, the direction and the enable. It marks the last state before a wrap: all ones when counting up, all zeros when counting down. A neighbouring stage can use it as its enable.

Top module: `bidir_preset_counter`

## Requirements
- R1: While `rst_i` is high, `count_o` is 0 at once, without a clock edge, whatever `load_i`, `data_i`, `cnt_en_n_i` and `up_i` are.
- R2: While `load_i` is high and `rst_i` is low, `count_o` equals `data_i` at once and follows changes on `data_i`, whatever the clock, enable or direction inputs do.
- R3: On a rising clock edge with `rst_i`, `load_i` and `cnt_en_n_i` all low and `up_i` = 1, the count increases by one.
- R4: On a rising clock edge with `rst_i`, `load_i` and `cnt_en_n_i` all low and `up_i` = 0, the count decreases by one.
- R5: With `cnt_en_n_i` high and neither `rst_i` nor `load_i` asserted, the count holds on every clock edge.
- R6: Counting up from the all-ones value (15 for WIDTH = 4) gives 0.
- R7: Counting down from 0 gives the all-ones value (15 for WIDTH = 4).
- R8: With `up_i` = 1, `tc_n_o` is 0 only when `count_o` is all ones and `cnt_en_n_i` is 0; otherwise it is 1.
- R9: With `up_i` = 0, `tc_n_o` is 0 only when `count_o` is 0 and `cnt_en_n_i` is 0; otherwise it is 1.
- R10: `tc_n_o` is combinational. It changes as soon as `cnt_en_n_i` or `up_i` changes, with no clock edge needed.
- R11: After `load_i` falls, the count keeps the preset value. It counts from that value on the first qualifying clock edge. `data_i` must stay steady from the last clock edge of the preset until the preset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Counting clock, rising edge |
| rst_i | input | 1 | Asynchronous clear, active high, highest priority |
| load_i | input | 1 | Asynchronous preset from `data_i`, active high, level-sensitive |
| cnt_en_n_i | input | 1 | Count enable, active low |
| up_i | input | 1 | Direction: 1 counts up, 0 counts down |
| data_i | input | WIDTH | Preset value |
| count_o | output | WIDTH | Current count |
| tc_n_o | output | 1 | Terminal count flag, active low |

## Verification
Two pairs of functions are made to coincide.

The first pair is clear and preset. Both are raised together with a non-zero preset value. The count must read zero, and it must take the preset value only once the clear is lowered.

The second pair is preset and counting. A clock edge arrives while the preset is held with the enable low. The count must stay on the data value across that edge, and it must step once from that value on the first edge after release.

// File: rtl/bpc_pkg.sv
package bpc_pkg;

    // What the counter does on the next clock edge
    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_INC  = 2'd1,
        OP_DEC  = 2'd2,
        OP_LOAD = 2'd3
    } bpc_op_e;

endpackage

// File: rtl/bpc_ctrl.sv
module bpc_ctrl
    import bpc_pkg::*;
(
    input  logic    load_i,
    input  logic    en_n_i,
    input  logic    up_i,
    output bpc_op_e op_o
);

    // Preset outranks counting; enable is active low
    always_comb begin
        if (load_i)       op_o = OP_LOAD;
        else if (en_n_i)  op_o = OP_HOLD;
        else if (up_i)    op_o = OP_INC;
        else              op_o = OP_DEC;
    end

endmodule

// File: rtl/bpc_step.sv
module bpc_step
    import bpc_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  bpc_op_e          op_i,
    input  logic [WIDTH-1:0] cur_i,
    input  logic [WIDTH-1:0] data_i,
    output logic [WIDTH-1:0] nxt_o
);

    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    // Modulo arithmetic gives both wraps for free
    always_comb begin
        unique case (op_i)
            OP_INC:  nxt_o = cur_i + ONE;
            OP_DEC:  nxt_o = cur_i - ONE;
            OP_LOAD: nxt_o = data_i;
            default: nxt_o = cur_i;
        endcase
    end

endmodule

// File: rtl/bpc_tc.sv
module bpc_tc #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] cnt_i,
    input  logic             en_n_i,
    input  logic             up_i,
    output logic             tc_n_o
);

    logic at_end;

    // Last state before a wrap in the selected direction
    always_comb begin
        at_end = up_i ? (&cnt_i) : ~(|cnt_i);
        tc_n_o = ~(at_end & ~en_n_i);
    end

endmodule

// File: rtl/bidir_preset_counter.sv
module bidir_preset_counter
    import bpc_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             load_i,
    input  logic             cnt_en_n_i,
    input  logic             up_i,
    input  logic [WIDTH-1:0] data_i,
    output logic [WIDTH-1:0] count_o,
    output logic             tc_n_o
);

    localparam logic [WIDTH-1:0] ONE   = WIDTH'(1);
    localparam logic [WIDTH-1:0] ALL_1 = {WIDTH{1'b1}};

    typedef struct packed {
        logic [WIDTH-1:0] cnt;
    } state_t;

    state_t           st_d, st_q;
    bpc_op_e          op;
    logic [WIDTH-1:0] nxt;

    bpc_ctrl u_ctrl (
        .load_i (load_i),
        .en_n_i (cnt_en_n_i),
        .up_i   (up_i),
        .op_o   (op)
    );

    bpc_step #(.WIDTH(WIDTH)) u_step (
        .op_i   (op),
        .cur_i  (st_q.cnt),
        .data_i (data_i),
        .nxt_o  (nxt)
    );

    always_comb begin
        st_d     = st_q;
        st_d.cnt = nxt;
    end

    // Clear and preset both act asynchronously on the flops
    always_ff @(posedge clk_i or posedge rst_i or posedge load_i) begin
        if (rst_i)       st_q     <= '0;
        else if (load_i) st_q.cnt <= data_i;
        else             st_q     <= st_d;
    end

    // Level-transparent output while a control is held
    always_comb begin
        if (rst_i)       count_o = '0;
        else if (load_i) count_o = data_i;
        else             count_o = st_q.cnt;
    end

    bpc_tc #(.WIDTH(WIDTH)) u_tc (
        .cnt_i  (count_o),
        .en_n_i (cnt_en_n_i),
        .up_i   (up_i),
        .tc_n_o (tc_n_o)
    );

    AST_CLEAR_ZERO: assert property (@(posedge clk_i)
        rst_i |-> count_o == '0);                                           // R1

    AST_PRESET_FOLLOW: assert property (@(posedge clk_i) disable iff (rst_i)
        load_i |-> count_o == data_i);                                      // R2

    AST_STEP_UP: assert property (@(posedge clk_i) disable iff (rst_i)
        ($past(!rst_i && !load_i && !cnt_en_n_i && up_i) && !load_i)
        |-> count_o == $past(count_o) + ONE);                               // R3

    AST_STEP_DOWN: assert property (@(posedge clk_i) disable iff (rst_i)
        ($past(!rst_i && !load_i && !cnt_en_n_i && !up_i) && !load_i)
        |-> count_o == $past(count_o) - ONE);                               // R4

    AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (rst_i)
        ($past(!rst_i && !load_i && cnt_en_n_i) && !load_i)
        |-> $stable(count_o));                                              // R5

    AST_TC_UP: assert property (@(posedge clk_i) disable iff (rst_i)
        up_i |-> (tc_n_o == !(count_o == ALL_1 && !cnt_en_n_i)));           // R8

    AST_TC_DOWN: assert property (@(posedge clk_i) disable iff (rst_i)
        !up_i |-> (tc_n_o == !(count_o == '0 && !cnt_en_n_i)));             // R9

endmodule

// File: tb/bidir_preset_counter_bench.sv
`timescale 1ns/1ps
module bidir_preset_counter_bench;

    localparam int WIDTH = 4;

    logic             clk = 1'b0;
    logic             rst_i = 1'b1;
    logic             load_i = 1'b0;
    logic             cnt_en_n_i = 1'b1;
    logic             up_i = 1'b1;
    logic [WIDTH-1:0] data_i = '0;
    logic [WIDTH-1:0] count_o;
    logic             tc_n_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    bidir_preset_counter #(.WIDTH(WIDTH)) u_bidir_preset_counter (
        .clk_i      (clk),
        .rst_i      (rst_i),
        .load_i     (load_i),
        .cnt_en_n_i (cnt_en_n_i),
        .up_i       (up_i),
        .data_i     (data_i),
        .count_o    (count_o),
        .tc_n_o     (tc_n_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic edge_then_sample();
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        // R1: count is zero while the clear is held, even with the preset raised
        #1;
        chk("R1 count under clear", count_o, 0);
        chk("R8 tc idle under clear", tc_n_o, 1);
        @(negedge clk);
        load_i = 1'b1; data_i = 4'd9;
        #0.5;
        chk("R1 clear beats preset", count_o, 0);
        @(negedge clk);
        rst_i = 1'b0;
        #0.5;
        chk("R2 preset after clear lowered", count_o, 9);
        @(negedge clk);
        rst_i = 1'b1;
        #0.5;
        chk("R1 async clear mid cycle", count_o, 0);
        @(negedge clk);
        rst_i = 1'b0; load_i = 1'b0;
        edge_then_sample();
        chk("R5 hold at zero after clear", count_o, 0);
    endtask

    task automatic t_preset();
        // R2: follows data with no clock edge; R11: resumes from the preset value
        @(negedge clk);
        load_i = 1'b1; data_i = 4'd5;
        #0.5;
        chk("R2 preset immediate", count_o, 5);
        data_i = 4'd10;
        #0.5;
        chk("R2 preset follows data", count_o, 10);
        cnt_en_n_i = 1'b0; up_i = 1'b1;
        edge_then_sample();
        chk("R2 preset holds across edge", count_o, 10);
        @(negedge clk);
        load_i = 1'b0;
        #0.5;
        chk("R11 value kept after release", count_o, 10);
        edge_then_sample();
        chk("R11 first count after release", count_o, 11);
    endtask

    task automatic t_count_up();
        // R3 steps, R8 decode, R10 combinational flag, R5 hold, R6 wrap
        edge_then_sample();
        chk("R3 up step", count_o, 12);
        edge_then_sample();
        edge_then_sample();
        chk("R3 up to 14", count_o, 14);
        chk("R8 tc high at 14", tc_n_o, 1);
        edge_then_sample();
        chk("R3 up to 15", count_o, 15);
        chk("R8 tc low at 15 enabled", tc_n_o, 0);
        @(negedge clk);
        cnt_en_n_i = 1'b1;
        #0.5;
        chk("R10 tc drops with enable", tc_n_o, 1);
        edge_then_sample();
        edge_then_sample();
        chk("R5 hold while disabled", count_o, 15);
        @(negedge clk);
        up_i = 1'b0; cnt_en_n_i = 1'b0;
        #0.5;
        chk("R9 tc high at 15 counting down", tc_n_o, 1);
        up_i = 1'b1;
        #0.5;
        chk("R10 tc follows direction", tc_n_o, 0);
        edge_then_sample();
        chk("R6 wrap up to zero", count_o, 0);
        chk("R8 tc high at zero counting up", tc_n_o, 1);
    endtask

    task automatic t_count_down();
        // R9 decode at zero, R7 wrap, R4 steps
        @(negedge clk);
        up_i = 1'b0;
        #0.5;
        chk("R9 tc low at zero counting down", tc_n_o, 0);
        edge_then_sample();
        chk("R7 wrap down to 15", count_o, 15);
        edge_then_sample();
        chk("R4 down step", count_o, 14);
        edge_then_sample();
        chk("R4 down to 13", count_o, 13);
        @(negedge clk);
        load_i = 1'b1; data_i = 4'd1;
        @(negedge clk);
        load_i = 1'b0;
        edge_then_sample();
        chk("R11 down from preset", count_o, 0);
        chk("R9 tc low after reaching zero", tc_n_o, 0);
        @(negedge clk);
        cnt_en_n_i = 1'b1;
        #0.5;
        chk("R9 tc high when disabled", tc_n_o, 1);
        edge_then_sample();
        chk("R5 hold at zero", count_o, 0);
    endtask

    initial begin
        t_reset();
        t_preset();
        t_count_up();
        t_count_down();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #20000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule